// File: doc/BRIEF.md
# Multichannel Conversion Scan Sequencer

This block is the control engine of an eight-channel sampled-data converter subsystem. A write to its mode/start port latches a new mode and launches a sequence of four or eight conversions. The conversions run either all on one chosen channel or on a run of consecutive channels. The k-th conversion of each sequence lands in result slot k. When a sequence ends, the block either goes idle or starts the next sequence at once, as the latched mode selects.

Every conversion follows a fixed timeline. The timeline is counted in conversion-clock ticks, and the conversion clock is the system clock divided by a programmable even ratio. A conversion has four phases: a 2-tick setup, a 4-tick pre-sample, a final sample of selectable length, and a 10-tick resolve. The analog core is reduced to a handshake. The block drives the active channel and the current phase, and an external stub returns an 8-bit code. The block takes that code in the last tick of the resolve phase.

Top module: `adc_scan_sequencer`

## Requirements
- R1: After reset the block is idle (`cnv_active`=0), `res_wr` and `seq_done` are 0, and every result slot reads back 0.
- R2: While `enable` is 0, a mode write is ignored and nothing converts. Dropping `enable` during a sequence stops it, and `cnv_active` is 0 in the following cycle.
- R3: A sequence holds 4 conversions when `mode_len8`=0 and 8 when it is 1. `seq_done` pulses together with the `res_wr` of the last conversion only.
- R4: With `mode_multi`=1, conversion k uses channel B+k. B is `mode_sel` with its low two bits cleared when the length is 4, and 0 when the length is 8.
- R5: With `mode_multi`=0, every conversion of the sequence uses channel `mode_sel`.
- R6: Consecutive result writes are exactly D*T system cycles apart, and so is the first write after the mode-write cycle. Here D = 2*(`mode_presc`+1), which gives 2..16. T = 16 + S, with S = 2 << `mode_samp`, which gives 2, 4, 8 or 16.
- R7: The k-th conversion writes slot k. `res_slot` shows k and `res_value` shows {code, 8'h00}. The same 16-bit word later reads back on `rd_data` when `rd_sel`=k.
- R8: With `mode_rescan`=0, the block is idle in the cycle of the final `res_wr` and writes nothing more. With `mode_rescan`=1, slot 0 of the next sequence follows with no gap.
- R9: A mode write during a sequence aborts it. The new sequence starts from slot 0 with a fresh timeline, so its first write comes D*T cycles after the write.
- R10: `cnv_phase` (0 setup, 1 pre-sample, 2 final sample, 3 resolve) is 0 in the cycle after a start. It only advances by one (mod 4), and it is 3 in the cycle before each result write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Subsystem power-up; 0 holds the block idle |
| mode_wr | input | 1 | One-cycle mode/start write strobe |
| mode_len8 | input | 1 | Sequence length: 0 = 4, 1 = 8 |
| mode_multi | input | 1 | 1 = consecutive channels, 0 = one channel |
| mode_rescan | input | 1 | 1 = restart sequence immediately when done |
| mode_sel | input | 3 | Channel or channel group select |
| mode_presc | input | 3 | Prescaler code, divide ratio 2*(code+1) |
| mode_samp | input | 2 | Final sample length code, 2 << code ticks |
| cnv_data | input | 8 | Code returned by the converter stub |
| cnv_active | output | 1 | Sequence in progress |
| cnv_ch | output | 3 | Channel under conversion |
| cnv_phase | output | 2 | Current conversion phase |
| res_wr | output | 1 | Result written this cycle |
| res_slot | output | 3 | Slot of the written result |
| res_value | output | 16 | Written result, code in upper byte |
| seq_done | output | 1 | Last result of a sequence written |
| rd_sel | input | 3 | Result slot read select |
| rd_data | output | 16 | Stored result of the selected slot |

## Verification
The bound checker watches four things on every cycle. It checks the conversion cycle budget against its own cycle counter. It checks that the phase only moves forward, that a start resets the timeline, and that a dropped enable or a finished one-shot sequence leaves the block idle. Channel order, slot placement, the stored values and the group masking of the select field can only be shown by the bench's scenarios. The same holds for the absence of writes after a one-shot sequence and the gapless rescan.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  localparam int NUM_CH   = 8;
  localparam int CH_W     = $clog2(NUM_CH);
  localparam int CODE_W   = 8;
  localparam int SLOT_W   = 16;
  localparam int PRE_W    = 3;
  localparam int SMP_W    = 2;
  localparam int DIV_W    = PRE_W + 2;
  localparam int CNT_W    = 6;
  localparam int LEN_W    = CH_W + 1;
  localparam int SETUP_TK = 2;
  localparam int PRE_TK   = 4;
  localparam int RSLV_TK  = 10;

  typedef enum logic [1:0] {PH_SETUP, PH_PRESAMP, PH_FINAL, PH_RESOLVE} phase_e;

  typedef struct packed {
    logic             len8;
    logic             multi;
    logic             rescan;
    logic [CH_W-1:0]  sel;
    logic [PRE_W-1:0] presc;
    logic [SMP_W-1:0] samp;
  } mode_t;

  // system clocks per conversion tick: 2..16
  function automatic logic [DIV_W-1:0] div_ratio(input logic [PRE_W-1:0] presc);
    return DIV_W'({presc, 1'b0}) + DIV_W'(2);
  endfunction

  // final sample phase length in ticks: 2,4,8,16
  function automatic logic [CNT_W-1:0] final_len(input logic [SMP_W-1:0] samp);
    return CNT_W'(2) << samp;
  endfunction

  function automatic logic [CNT_W-1:0] conv_ticks(input logic [SMP_W-1:0] samp);
    return CNT_W'(SETUP_TK + PRE_TK + RSLV_TK) + final_len(samp);
  endfunction

  function automatic logic [LEN_W-1:0] seq_len(input logic len8);
    return len8 ? LEN_W'(8) : LEN_W'(4);
  endfunction

  function automatic logic [CH_W-1:0] chan_for(input mode_t m, input logic [CH_W-1:0] slot);
    logic [CH_W-1:0] mask;
    logic [CH_W-1:0] base;
    mask = CH_W'(seq_len(m.len8) - LEN_W'(1));
    base = m.sel & ~mask;
    return m.multi ? (base + slot) : m.sel;
  endfunction

  function automatic phase_e phase_of(input logic [CNT_W-1:0] cc, input logic [SMP_W-1:0] samp);
    if (cc < CNT_W'(SETUP_TK))                            return PH_SETUP;
    else if (cc < CNT_W'(SETUP_TK + PRE_TK))              return PH_PRESAMP;
    else if (cc < CNT_W'(SETUP_TK + PRE_TK) + final_len(samp)) return PH_FINAL;
    else                                                  return PH_RESOLVE;
  endfunction
endpackage

// File: rtl/adcseq_prescaler.sv
module adcseq_prescaler
  import adcseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [PRE_W-1:0] presc,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] last;

  assign last = div_ratio(presc) - DIV_W'(1);
  assign tick = !clear && (cnt_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clear) cnt_q <= '0;
    else if (tick)  cnt_q <= '0;
    else            cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/adcseq_phase_timer.sv
module adcseq_phase_timer
  import adcseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             tick,
  input  logic [SMP_W-1:0] samp,
  output phase_e           phase,
  output logic             conv_end
);
  logic [CNT_W-1:0] cc_q;
  logic [CNT_W-1:0] last;

  assign last     = conv_ticks(samp) - CNT_W'(1);
  assign conv_end = tick && (cc_q == last);
  assign phase    = phase_of(cc_q, samp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cc_q <= '0;
    else if (clear)    cc_q <= '0;
    else if (conv_end) cc_q <= '0;
    else if (tick)     cc_q <= cc_q + CNT_W'(1);
  end
endmodule

// File: rtl/adcseq_result_bank.sv
module adcseq_result_bank
  import adcseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_idx,
  input  logic [CODE_W-1:0] wr_code,
  input  logic [CH_W-1:0]   rd_idx,
  output logic [SLOT_W-1:0] rd_data
);
  logic [CODE_W-1:0] slot_q [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              slot_q[g] <= '0;
      else if (wr_en && wr_idx == CH_W'(g))    slot_q[g] <= wr_code;
    end
  end

  assign rd_data = {slot_q[rd_idx], {(SLOT_W-CODE_W){1'b0}}};
endmodule

// File: rtl/adc_scan_sequencer.sv
module adc_scan_sequencer
  import adcseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              mode_wr,
  input  logic              mode_len8,
  input  logic              mode_multi,
  input  logic              mode_rescan,
  input  logic [CH_W-1:0]   mode_sel,
  input  logic [PRE_W-1:0]  mode_presc,
  input  logic [SMP_W-1:0]  mode_samp,
  input  logic [CODE_W-1:0] cnv_data,
  output logic              cnv_active,
  output logic [CH_W-1:0]   cnv_ch,
  output logic [1:0]        cnv_phase,
  output logic              res_wr,
  output logic [CH_W-1:0]   res_slot,
  output logic [SLOT_W-1:0] res_value,
  output logic              seq_done,
  input  logic [CH_W-1:0]   rd_sel,
  output logic [SLOT_W-1:0] rd_data
);
  mode_t           mode_q;
  mode_t           mode_new;
  logic            busy;
  logic [CH_W-1:0] slot_q;

  // named internal events
  logic   start_acc;
  logic   timer_clear;
  logic   tick;
  logic   conv_end;
  logic   seq_last;
  logic   write_now;
  phase_e phase;

  assign mode_new    = '{len8: mode_len8, multi: mode_multi, rescan: mode_rescan,
                         sel: mode_sel, presc: mode_presc, samp: mode_samp};
  assign start_acc   = enable && mode_wr;
  assign timer_clear = start_acc || !busy;
  assign seq_last    = (slot_q == CH_W'(seq_len(mode_q.len8) - LEN_W'(1)));
  assign write_now   = conv_end && enable && !start_acc;

  adcseq_prescaler u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (timer_clear),
    .presc (mode_q.presc),
    .tick  (tick)
  );

  adcseq_phase_timer u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (timer_clear),
    .tick     (tick),
    .samp     (mode_q.samp),
    .phase    (phase),
    .conv_end (conv_end)
  );

  adcseq_result_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (write_now),
    .wr_idx  (slot_q),
    .wr_code (cnv_data),
    .rd_idx  (rd_sel),
    .rd_data (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= '0;
      busy      <= 1'b0;
      slot_q    <= '0;
      res_wr    <= 1'b0;
      res_slot  <= '0;
      res_value <= '0;
      seq_done  <= 1'b0;
    end else begin
      res_wr   <= 1'b0;
      seq_done <= 1'b0;
      if (start_acc) begin
        mode_q <= mode_new;
        busy   <= 1'b1;
        slot_q <= '0;
      end else if (!enable) begin
        busy   <= 1'b0;
        slot_q <= '0;
      end else if (write_now) begin
        res_wr    <= 1'b1;
        res_slot  <= slot_q;
        res_value <= {cnv_data, {(SLOT_W-CODE_W){1'b0}}};
        if (seq_last) begin
          seq_done <= 1'b1;
          slot_q   <= '0;
          busy     <= mode_q.rescan;
        end else begin
          slot_q <= slot_q + CH_W'(1);
        end
      end
    end
  end

  assign cnv_active = busy;
  assign cnv_ch     = chan_for(mode_q, slot_q);
  assign cnv_phase  = phase;
endmodule

// File: rtl/adcseq_checker.sv
module adcseq_checker
  import adcseq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             start_acc,
  input logic             conv_end,
  input logic             busy,
  input logic             rescan,
  input logic [PRE_W-1:0] presc,
  input logic [SMP_W-1:0] samp,
  input logic [1:0]       cnv_phase,
  input logic             res_wr,
  input logic             seq_done
);
  logic [15:0] gap_q;
  int unsigned budget;

  assign budget = int'(div_ratio(presc)) * int'(conv_ticks(samp)) - 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      gap_q <= '0;
    else if (start_acc || conv_end)  gap_q <= '0;
    else if (busy)                   gap_q <= gap_q + 16'd1;
  end

  // R6
  conv_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_end |-> (32'(gap_q) == budget));

  // R2
  enable_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !busy);

  // R3
  done_with_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> res_wr);

  // R8
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done && !rescan) |-> !busy);

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> (busy && cnv_phase == 2'd0));

  // R10
  phase_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(start_acc) && cnv_phase != $past(cnv_phase))
      |-> (cnv_phase == $past(cnv_phase) + 2'd1));
endmodule

bind adc_scan_sequencer adcseq_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .start_acc (start_acc),
  .conv_end  (conv_end),
  .busy      (busy),
  .rescan    (mode_q.rescan),
  .presc     (mode_q.presc),
  .samp      (mode_q.samp),
  .cnv_phase (cnv_phase),
  .res_wr    (res_wr),
  .seq_done  (seq_done)
);

// File: tb/adc_scan_sequencer_bench.sv
module adc_scan_sequencer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        mode_wr = 1'b0;
  logic        mode_len8 = 1'b0;
  logic        mode_multi = 1'b0;
  logic        mode_rescan = 1'b0;
  logic [2:0]  mode_sel = '0;
  logic [2:0]  mode_presc = '0;
  logic [1:0]  mode_samp = '0;
  logic [7:0]  cnv_data;
  logic        cnv_active;
  logic [2:0]  cnv_ch;
  logic [1:0]  cnv_phase;
  logic        res_wr;
  logic [2:0]  res_slot;
  logic [15:0] res_value;
  logic        seq_done;
  logic [2:0]  rd_sel = '0;
  logic [15:0] rd_data;
  logic [4:0]  tag = '0;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  // converter stub: code = {channel, tag}
  assign cnv_data = {cnv_ch, tag};

  adc_scan_sequencer u_adc_scan_sequencer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode_wr(mode_wr),
    .mode_len8(mode_len8), .mode_multi(mode_multi), .mode_rescan(mode_rescan),
    .mode_sel(mode_sel), .mode_presc(mode_presc), .mode_samp(mode_samp),
    .cnv_data(cnv_data), .cnv_active(cnv_active), .cnv_ch(cnv_ch),
    .cnv_phase(cnv_phase), .res_wr(res_wr), .res_slot(res_slot),
    .res_value(res_value), .seq_done(seq_done), .rd_sel(rd_sel), .rd_data(rd_data)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int budget(input int presc, input int samp);
    int d;
    int s;
    d = 2 * (presc + 1);
    s = 2;
    for (int i = 0; i < samp; i++) s = s * 2;
    return d * (16 + s);
  endfunction

  function automatic int exp_chan(input bit len8, input bit multi, input int sel, input int k);
    if (!multi) return sel;
    if (len8) return k;
    return (sel / 4) * 4 + k;
  endfunction

  task automatic start(input bit len8, input bit multi, input bit rescan,
                       input int sel, input int presc, input int samp);
    @(negedge clk);
    mode_len8 = len8; mode_multi = multi; mode_rescan = rescan;
    mode_sel = 3'(sel); mode_presc = 3'(presc); mode_samp = 2'(samp);
    mode_wr = 1'b1;
    @(negedge clk);
    mode_wr = 1'b0;
    check(cnv_active == 1'b1, "R9", "busy after start", cnv_active, 1);
    check(cnv_phase == 2'd0, "R10", "phase after start", cnv_phase, 0);
  endtask

  task automatic wait_res(output int gap, output int prev_ph);
    gap = 0;
    prev_ph = cnv_phase;
    while (gap < 5000) begin
      @(negedge clk);
      gap++;
      if (res_wr) break;
      prev_ph = cnv_phase;
    end
  endtask

  task automatic t_reset;
    check(cnv_active == 0, "R1", "busy at reset", cnv_active, 0);
    check(res_wr == 0, "R1", "res_wr at reset", res_wr, 0);
    check(seq_done == 0, "R1", "seq_done at reset", seq_done, 0);
    for (int k = 0; k < 8; k++) begin
      rd_sel = 3'(k);
      #1;
      check(rd_data == 16'h0, "R1", "slot at reset", rd_data, 0);
    end
  endtask

  task automatic t_disabled;
    int writes = 0;
    enable = 1'b0;
    @(negedge clk);
    mode_len8 = 0; mode_multi = 1; mode_sel = 0; mode_presc = 0; mode_samp = 0;
    mode_wr = 1'b1;
    @(negedge clk);
    mode_wr = 1'b0;
    for (int i = 0; i < 100; i++) begin
      if (res_wr || cnv_active) writes++;
      @(negedge clk);
    end
    check(writes == 0, "R2", "activity while disabled", writes, 0);
    enable = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_oneshot(input bit len8, input bit multi, input int sel,
                           input int presc, input int samp, input int tg);
    int n;
    int dt;
    int gap;
    int pph;
    int ch;
    int extra = 0;
    string rq;
    n = len8 ? 8 : 4;
    dt = budget(presc, samp);
    rq = multi ? "R4" : "R5";
    tag = 5'(tg);
    start(len8, multi, 1'b0, sel, presc, samp);
    for (int k = 0; k < n; k++) begin
      wait_res(gap, pph);
      ch = exp_chan(len8, multi, sel, k);
      check(gap == dt, "R6", "write spacing", gap, dt);
      check(res_slot == 3'(k), "R7", "slot order", res_slot, k);
      check(res_value == {3'(ch), 5'(tg), 8'h00}, rq, "result value/channel",
            res_value, {3'(ch), 5'(tg), 8'h00});
      check(pph == 3, "R10", "phase before write", pph, 3);
      check(seq_done == (k == n - 1), "R3", "seq_done position", seq_done, k == n - 1);
      if (k == n - 1) check(cnv_active == 0, "R8", "idle after one-shot", cnv_active, 0);
    end
    for (int i = 0; i < 2 * dt; i++) begin
      @(negedge clk);
      if (res_wr) extra++;
    end
    check(extra == 0, "R8", "writes after one-shot", extra, 0);
    for (int k = 0; k < n; k++) begin
      ch = exp_chan(len8, multi, sel, k);
      rd_sel = 3'(k);
      #1;
      check(rd_data == {3'(ch), 5'(tg), 8'h00}, "R7", "stored slot", rd_data,
            {3'(ch), 5'(tg), 8'h00});
    end
  endtask

  task automatic t_rescan;
    int gap;
    int pph;
    int extra = 0;
    tag = 5'd9;
    start(1'b0, 1'b1, 1'b1, 1, 0, 0);
    for (int k = 0; k < 6; k++) begin
      wait_res(gap, pph);
      check(gap == 36, "R8", "rescan spacing", gap, 36);
      check(res_slot == 3'(k % 4), "R8", "rescan slot", res_slot, k % 4);
      check(res_value[15:13] == 3'(k % 4), "R4", "rescan channel", res_value[15:13], k % 4);
      if (k == 3) begin
        check(seq_done == 1, "R3", "rescan done pulse", seq_done, 1);
        check(cnv_active == 1, "R8", "still busy on rescan", cnv_active, 1);
      end
    end
    enable = 1'b0;
    @(negedge clk);
    check(cnv_active == 0, "R2", "stop on enable drop", cnv_active, 0);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (res_wr) extra++;
    end
    check(extra == 0, "R2", "writes after disable", extra, 0);
    enable = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_abort;
    int gap;
    int pph;
    tag = 5'd3;
    start(1'b1, 1'b1, 1'b0, 0, 0, 1);
    for (int k = 0; k < 3; k++) wait_res(gap, pph);
    repeat (10) @(negedge clk);
    tag = 5'd22;
    start(1'b0, 1'b1, 1'b0, 6, 0, 0);
    for (int k = 0; k < 4; k++) begin
      wait_res(gap, pph);
      check(gap == 36, "R9", "spacing after restart", gap, 36);
      check(res_slot == 3'(k), "R9", "slot after restart", res_slot, k);
      check(res_value[15:13] == 3'(4 + k), "R4", "group channel", res_value[15:13], 4 + k);
      check(seq_done == (k == 3), "R3", "restart seq_done", seq_done, k == 3);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        failures++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_oneshot(1'b0, 1'b1, 5, 0, 0, 7);
    t_oneshot(1'b1, 1'b1, 3, 1, 1, 12);
    t_oneshot(1'b0, 1'b0, 5, 7, 3, 30);
    t_oneshot(1'b1, 1'b0, 2, 0, 3, 1);
    t_rescan();
    t_abort();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule